// File: doc/BRIEF.md
# Classification Action Resolver

This block sits behind the rule-matching stage of a packet classifier. It takes the action record of the rule that won the lookup, together with the results the default classification path has already produced, and turns them into one registered bundle of per-packet decisions. The bundle holds the egress port map, the address-learning feedback, the traffic class, two meter slot assignments, the VLAN ID, the filter-bypass and marking flags, the interrupt and timestamp requests, the remark permissions and the flow-ID tag.

Each action group in the record is resolved on its own. Most groups use a small code in which zero leaves the default untouched, and a higher code overrides it. The multicast-snooping group ranks above the forwarding group. The learning group can force learning on or off against the forwarding result. When no rule hits, every output takes its default value. Decisions appear one clock after the inputs, and a valid bit travels alongside them.

Top module: `cls_action_resolver`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero.
- R2: When rule_hit is 0, the outputs are as follows. The port map equals dflt_port_map and the learn output equals fwd_ok. The class equals dflt_tc and the VLAN equals dflt_vid. Both meter slots, all five flags, the multicast bits, the conflict bit and the flow tag are 0. The snoop type is 0, and all three remark permissions are 1.
- R3: When a rule hits and snoop_mode is 0, fwd_mode selects the port map. Codes 0 and 1 give dflt_port_map, and code 2 gives an empty map. Code 3 gives a map with only bit cpu_port set, or an empty map when cpu_port is not below NUM_PORTS. Code 4 gives alt_port_map, with port 0 on the LSB. Code 5 gives dflt_port_map and sets mc_router. Code 6 gives dflt_port_map and sets mc_learn. Code 7 gives dflt_port_map.
- R4: When a rule hits and snoop_mode is nonzero, fwd_mode is ignored. The map is dflt_port_map, both multicast bits are 0, and snoop_type carries snoop_mode (codes 0..7).
- R5: On a hit, learn_mode sets the learn output. Codes 0 and 1 give fwd_ok, code 2 gives 0 and code 3 gives 1.
- R6: On a hit, tc_mode 2 selects alt_tc. Codes 0, 1 and 3 select dflt_tc.
- R7: On a hit, meter_mode sets the two meter slots. Code 0 enables neither. Code 1 enables slot 0 with meter_base. Code 2 enables slot 1 with meter_base. Code 3 enables slot 0 with meter_base and slot 1 with meter_base+1, modulo 2^METER_W. A disabled slot reports ID 0.
- R8: On a hit, vlan_mode 2 selects alt_vid. Any other code selects dflt_vid.
- R9: Five flags share one 2-bit code: the state bypass, the VLAN bypass, the critical mark, the interrupt request and the timestamp request. Each flag is 1 only when a rule hits and its code is 2. Codes 0, 1 and 3 give 0.
- R10: On a hit, each remark permission (PCP, DSCP, class) equals its rule flag. A 0 forces remarking off.
- R11: On a hit with flow_id_en set, the flow tag is enabled and carries flow_id. If fwd_mode is also 4, conflict is 1, the flow tag is suppressed (enable 0, ID 0) and the port map still follows R3/R4.
- R12: Every output reflects the inputs of the previous clock edge, and out_valid equals the previous in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet present this cycle |
| rule_hit | input | 1 | A rule matched |
| fwd_mode | input | 3 | Forwarding code |
| snoop_mode | input | 3 | Multicast-snooping code |
| learn_mode | input | 2 | Learning code |
| tc_mode | input | 2 | Traffic-class code |
| meter_mode | input | 2 | Meter code |
| vlan_mode | input | 2 | VLAN code |
| xstate_mode | input | 2 | State-bypass code |
| xvlan_mode | input | 2 | VLAN-bypass code |
| crit_mode | input | 2 | Critical-mark code |
| irq_mode | input | 2 | Interrupt code |
| tstamp_mode | input | 2 | Timestamp code |
| alt_port_map | input | NUM_PORTS | Rule port map |
| alt_tc | input | TC_W | Rule traffic class |
| alt_vid | input | VID_W | Rule VLAN ID |
| meter_base | input | METER_W | Rule meter number |
| remark_pcp_en | input | 1 | Permit PCP remark |
| remark_dscp_en | input | 1 | Permit DSCP remark |
| remark_cls_en | input | 1 | Permit class remark |
| flow_id_en | input | 1 | Flow tag requested |
| flow_id | input | FLOW_W | Flow tag value |
| dflt_port_map | input | NUM_PORTS | Default port map |
| dflt_tc | input | TC_W | Default class |
| dflt_vid | input | VID_W | Default VLAN |
| cpu_port | input | PORT_IDX_W | CPU port index |
| fwd_ok | input | 1 | Packet reaches at least one egress port |
| out_valid | output | 1 | Decision valid |
| out_port_map | output | NUM_PORTS | Egress port map |
| out_mc_router | output | 1 | Multicast router/query packet |
| out_mc_learn | output | 1 | Learn into multicast group table |
| out_snoop_type | output | 3 | Snooping message type |
| out_learn | output | 1 | Learn source address |
| out_tc | output | TC_W | Traffic class |
| out_meter0_en | output | 1 | Meter slot 0 used |
| out_meter0_id | output | METER_W | Meter slot 0 ID |
| out_meter1_en | output | 1 | Meter slot 1 used |
| out_meter1_id | output | METER_W | Meter slot 1 ID |
| out_vid | output | VID_W | VLAN ID |
| out_bypass_state | output | 1 | Skip port-state filter |
| out_bypass_vlan | output | 1 | Skip VLAN filter |
| out_critical | output | 1 | Critical frame |
| out_irq | output | 1 | Interrupt event |
| out_tstamp | output | 1 | Store timestamps |
| out_remark_pcp | output | 1 | PCP remark permitted |
| out_remark_dscp | output | 1 | DSCP remark permitted |
| out_remark_cls | output | 1 | Class remark permitted |
| out_flow_en | output | 1 | Flow tag enabled |
| out_flow_id | output | FLOW_W | Flow tag |
| out_conflict | output | 1 | Flow tag and alternative map both requested |

## Verification
The bench builds the block with NUM_PORTS=6, so the 3-bit cpu_port can take the values 6 and 7. These values are out of range and must produce an empty map. METER_W is set to 3, so random meter bases often land on 7, where the pair assignment wraps slot 1 to 0. FLOW_W is narrowed to 8, while TC_W and VID_W stay at their defaults. Random stimulus covers all code values, including the unassigned ones, and directed vectors pin the snoop override, the conflict case and forced learning against both forwarding results.

// File: rtl/cls_act_pkg.sv
package cls_act_pkg;

    typedef enum logic [2:0] {
        FWD_OFF      = 3'd0,
        FWD_DEFAULT  = 3'd1,
        FWD_DROP     = 3'd2,
        FWD_CPU      = 3'd3,
        FWD_ALT_MAP  = 3'd4,
        FWD_MC_RTR   = 3'd5,
        FWD_MC_LEARN = 3'd6,
        FWD_RSVD     = 3'd7
    } fwd_code_e;

    typedef enum logic [1:0] {
        LRN_NONE   = 2'd0,
        LRN_FOLLOW = 2'd1,
        LRN_NEVER  = 2'd2,
        LRN_ALWAYS = 2'd3
    } learn_code_e;

    typedef enum logic [1:0] {
        MTR_NONE = 2'd0,
        MTR_S0   = 2'd1,
        MTR_S1   = 2'd2,
        MTR_PAIR = 2'd3
    } meter_code_e;

    // shared by class, VLAN and the five flag groups
    localparam logic [1:0] SEL_OVERRIDE = 2'd2;

    localparam int NUM_FLAGS = 5;
    localparam int FL_XSTATE = 0;
    localparam int FL_XVLAN  = 1;
    localparam int FL_CRIT   = 2;
    localparam int FL_IRQ    = 3;
    localparam int FL_TSTAMP = 4;

endpackage

// File: rtl/cls_fwd_resolve.sv
module cls_fwd_resolve
    import cls_act_pkg::*;
#(
    parameter int NUM_PORTS  = 12,
    parameter int PORT_IDX_W = 4
) (
    input  logic                  hit,
    input  logic [2:0]            fwd_mode,
    input  logic [2:0]            snoop_mode,
    input  logic [1:0]            learn_mode,
    input  logic [NUM_PORTS-1:0]  alt_map,
    input  logic [NUM_PORTS-1:0]  dflt_map,
    input  logic [PORT_IDX_W-1:0] cpu_port,
    input  logic                  fwd_ok,
    output logic [NUM_PORTS-1:0]  port_map,
    output logic                  mc_router,
    output logic                  mc_learn,
    output logic                  learn
);

    logic [NUM_PORTS-1:0] cpu_map;

    always_comb begin
        cpu_map = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (cpu_port == PORT_IDX_W'(p)) cpu_map[p] = 1'b1;
        end
    end

    always_comb begin
        port_map  = dflt_map;
        mc_router = 1'b0;
        mc_learn  = 1'b0;
        if (hit && (snoop_mode == 3'd0)) begin
            case (fwd_code_e'(fwd_mode))
                FWD_DROP:     port_map = '0;
                FWD_CPU:      port_map = cpu_map;
                FWD_ALT_MAP:  port_map = alt_map;
                FWD_MC_RTR:   mc_router = 1'b1;
                FWD_MC_LEARN: mc_learn  = 1'b1;
                default:      port_map = dflt_map;
            endcase
        end
    end

    always_comb begin
        learn = fwd_ok;
        if (hit) begin
            case (learn_code_e'(learn_mode))
                LRN_NEVER:  learn = 1'b0;
                LRN_ALWAYS: learn = 1'b1;
                default:    learn = fwd_ok;
            endcase
        end
    end

endmodule

// File: rtl/cls_qos_resolve.sv
module cls_qos_resolve
    import cls_act_pkg::*;
#(
    parameter int TC_W    = 4,
    parameter int VID_W   = 12,
    parameter int METER_W = 6
) (
    input  logic               hit,
    input  logic [1:0]         tc_mode,
    input  logic [TC_W-1:0]    alt_tc,
    input  logic [TC_W-1:0]    dflt_tc,
    input  logic [1:0]         vlan_mode,
    input  logic [VID_W-1:0]   alt_vid,
    input  logic [VID_W-1:0]   dflt_vid,
    input  logic [1:0]         meter_mode,
    input  logic [METER_W-1:0] meter_base,
    output logic [TC_W-1:0]    tc,
    output logic [VID_W-1:0]   vid,
    output logic               m0_en,
    output logic [METER_W-1:0] m0_id,
    output logic               m1_en,
    output logic [METER_W-1:0] m1_id
);

    always_comb begin
        tc  = (hit && tc_mode == SEL_OVERRIDE) ? alt_tc : dflt_tc;
        vid = (hit && vlan_mode == SEL_OVERRIDE) ? alt_vid : dflt_vid;
    end

    always_comb begin
        m0_en = 1'b0;
        m0_id = '0;
        m1_en = 1'b0;
        m1_id = '0;
        if (hit) begin
            case (meter_code_e'(meter_mode))
                MTR_S0: begin
                    m0_en = 1'b1;
                    m0_id = meter_base;
                end
                MTR_S1: begin
                    m1_en = 1'b1;
                    m1_id = meter_base;
                end
                MTR_PAIR: begin
                    m0_en = 1'b1;
                    m0_id = meter_base;
                    m1_en = 1'b1;
                    m1_id = meter_base + METER_W'(1);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cls_tri_flag.sv
module cls_tri_flag
    import cls_act_pkg::*;
(
    input  logic       hit,
    input  logic [1:0] mode,
    output logic       flag
);

    always_comb flag = hit && (mode == SEL_OVERRIDE);

endmodule

// File: rtl/cls_action_resolver.sv
module cls_action_resolver
    import cls_act_pkg::*;
#(
    parameter int NUM_PORTS  = 12,
    parameter int PORT_IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    parameter int TC_W       = 4,
    parameter int VID_W      = 12,
    parameter int METER_W    = 6,
    parameter int FLOW_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  rule_hit,
    input  logic [2:0]            fwd_mode,
    input  logic [2:0]            snoop_mode,
    input  logic [1:0]            learn_mode,
    input  logic [1:0]            tc_mode,
    input  logic [1:0]            meter_mode,
    input  logic [1:0]            vlan_mode,
    input  logic [1:0]            xstate_mode,
    input  logic [1:0]            xvlan_mode,
    input  logic [1:0]            crit_mode,
    input  logic [1:0]            irq_mode,
    input  logic [1:0]            tstamp_mode,
    input  logic [NUM_PORTS-1:0]  alt_port_map,
    input  logic [TC_W-1:0]       alt_tc,
    input  logic [VID_W-1:0]      alt_vid,
    input  logic [METER_W-1:0]    meter_base,
    input  logic                  remark_pcp_en,
    input  logic                  remark_dscp_en,
    input  logic                  remark_cls_en,
    input  logic                  flow_id_en,
    input  logic [FLOW_W-1:0]     flow_id,
    input  logic [NUM_PORTS-1:0]  dflt_port_map,
    input  logic [TC_W-1:0]       dflt_tc,
    input  logic [VID_W-1:0]      dflt_vid,
    input  logic [PORT_IDX_W-1:0] cpu_port,
    input  logic                  fwd_ok,
    output logic                  out_valid,
    output logic [NUM_PORTS-1:0]  out_port_map,
    output logic                  out_mc_router,
    output logic                  out_mc_learn,
    output logic [2:0]            out_snoop_type,
    output logic                  out_learn,
    output logic [TC_W-1:0]       out_tc,
    output logic                  out_meter0_en,
    output logic [METER_W-1:0]    out_meter0_id,
    output logic                  out_meter1_en,
    output logic [METER_W-1:0]    out_meter1_id,
    output logic [VID_W-1:0]      out_vid,
    output logic                  out_bypass_state,
    output logic                  out_bypass_vlan,
    output logic                  out_critical,
    output logic                  out_irq,
    output logic                  out_tstamp,
    output logic                  out_remark_pcp,
    output logic                  out_remark_dscp,
    output logic                  out_remark_cls,
    output logic                  out_flow_en,
    output logic [FLOW_W-1:0]     out_flow_id,
    output logic                  out_conflict
);

    typedef struct packed {
        logic                 vld;
        logic [NUM_PORTS-1:0] pmap;
        logic                 mc_rtr;
        logic                 mc_lrn;
        logic [2:0]           snoop;
        logic                 learn;
        logic [TC_W-1:0]      tc;
        logic                 m0_en;
        logic [METER_W-1:0]   m0_id;
        logic                 m1_en;
        logic [METER_W-1:0]   m1_id;
        logic [VID_W-1:0]     vid;
        logic [NUM_FLAGS-1:0] flags;
        logic                 rmk_pcp;
        logic                 rmk_dscp;
        logic                 rmk_cls;
        logic                 flow_en;
        logic [FLOW_W-1:0]    flow;
        logic                 conflict;
    } decision_t;

    decision_t dec_d, dec_q;

    logic [NUM_PORTS-1:0] fr_map;
    logic                 fr_mc_rtr, fr_mc_lrn, fr_learn;
    logic [TC_W-1:0]      qr_tc;
    logic [VID_W-1:0]     qr_vid;
    logic                 qr_m0_en, qr_m1_en;
    logic [METER_W-1:0]   qr_m0_id, qr_m1_id;
    logic [NUM_FLAGS-1:0] flag_vec;
    logic [1:0]           flag_mode [NUM_FLAGS];

    cls_fwd_resolve #(
        .NUM_PORTS  (NUM_PORTS),
        .PORT_IDX_W (PORT_IDX_W)
    ) i_fwd (
        .hit        (rule_hit),
        .fwd_mode   (fwd_mode),
        .snoop_mode (snoop_mode),
        .learn_mode (learn_mode),
        .alt_map    (alt_port_map),
        .dflt_map   (dflt_port_map),
        .cpu_port   (cpu_port),
        .fwd_ok     (fwd_ok),
        .port_map   (fr_map),
        .mc_router  (fr_mc_rtr),
        .mc_learn   (fr_mc_lrn),
        .learn      (fr_learn)
    );

    cls_qos_resolve #(
        .TC_W    (TC_W),
        .VID_W   (VID_W),
        .METER_W (METER_W)
    ) i_qos (
        .hit        (rule_hit),
        .tc_mode    (tc_mode),
        .alt_tc     (alt_tc),
        .dflt_tc    (dflt_tc),
        .vlan_mode  (vlan_mode),
        .alt_vid    (alt_vid),
        .dflt_vid   (dflt_vid),
        .meter_mode (meter_mode),
        .meter_base (meter_base),
        .tc         (qr_tc),
        .vid        (qr_vid),
        .m0_en      (qr_m0_en),
        .m0_id      (qr_m0_id),
        .m1_en      (qr_m1_en),
        .m1_id      (qr_m1_id)
    );

    always_comb begin
        flag_mode[FL_XSTATE] = xstate_mode;
        flag_mode[FL_XVLAN]  = xvlan_mode;
        flag_mode[FL_CRIT]   = crit_mode;
        flag_mode[FL_IRQ]    = irq_mode;
        flag_mode[FL_TSTAMP] = tstamp_mode;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        cls_tri_flag i_flag (
            .hit  (rule_hit),
            .mode (flag_mode[g]),
            .flag (flag_vec[g])
        );
    end

    always_comb begin
        logic clash;
        clash = rule_hit && flow_id_en && (fwd_mode == FWD_ALT_MAP);

        dec_d          = '0;
        dec_d.vld      = in_valid;
        dec_d.pmap     = fr_map;
        dec_d.mc_rtr   = fr_mc_rtr;
        dec_d.mc_lrn   = fr_mc_lrn;
        dec_d.snoop    = rule_hit ? snoop_mode : 3'd0;
        dec_d.learn    = fr_learn;
        dec_d.tc       = qr_tc;
        dec_d.m0_en    = qr_m0_en;
        dec_d.m0_id    = qr_m0_id;
        dec_d.m1_en    = qr_m1_en;
        dec_d.m1_id    = qr_m1_id;
        dec_d.vid      = qr_vid;
        dec_d.flags    = flag_vec;
        dec_d.rmk_pcp  = rule_hit ? remark_pcp_en  : 1'b1;
        dec_d.rmk_dscp = rule_hit ? remark_dscp_en : 1'b1;
        dec_d.rmk_cls  = rule_hit ? remark_cls_en  : 1'b1;
        dec_d.conflict = clash;
        dec_d.flow_en  = rule_hit && flow_id_en && !clash;
        dec_d.flow     = dec_d.flow_en ? flow_id : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign out_valid        = dec_q.vld;
    assign out_port_map     = dec_q.pmap;
    assign out_mc_router    = dec_q.mc_rtr;
    assign out_mc_learn     = dec_q.mc_lrn;
    assign out_snoop_type   = dec_q.snoop;
    assign out_learn        = dec_q.learn;
    assign out_tc           = dec_q.tc;
    assign out_meter0_en    = dec_q.m0_en;
    assign out_meter0_id    = dec_q.m0_id;
    assign out_meter1_en    = dec_q.m1_en;
    assign out_meter1_id    = dec_q.m1_id;
    assign out_vid          = dec_q.vid;
    assign out_bypass_state = dec_q.flags[FL_XSTATE];
    assign out_bypass_vlan  = dec_q.flags[FL_XVLAN];
    assign out_critical     = dec_q.flags[FL_CRIT];
    assign out_irq          = dec_q.flags[FL_IRQ];
    assign out_tstamp       = dec_q.flags[FL_TSTAMP];
    assign out_remark_pcp   = dec_q.rmk_pcp;
    assign out_remark_dscp  = dec_q.rmk_dscp;
    assign out_remark_cls   = dec_q.rmk_cls;
    assign out_flow_en      = dec_q.flow_en;
    assign out_flow_id      = dec_q.flow;
    assign out_conflict     = dec_q.conflict;

    a_r3_drop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rule_hit && snoop_mode == 3'd0 && fwd_mode == 3'd2) |=> (out_port_map == '0));

    a_r4_snoop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rule_hit && snoop_mode != 3'd0) |=>
            (out_port_map == $past(dflt_port_map) && !out_mc_router && !out_mc_learn));

    a_r5_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rule_hit && learn_mode == 2'd2) |=> !out_learn);

    a_r5_forced_on: assert property (@(posedge clk) disable iff (!rst_n)
        (rule_hit && learn_mode == 2'd3) |=> out_learn);

    a_r2_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rule_hit |=> (!out_irq && !out_meter0_en && !out_meter1_en && !out_conflict));

    a_r7_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (out_meter0_en && out_meter1_en) |-> (out_meter1_id == out_meter0_id + METER_W'(1)));

    a_r11_no_flow_on_clash: assert property (@(posedge clk) disable iff (!rst_n)
        out_conflict |-> (!out_flow_en && out_flow_id == '0));

    a_r12_valid_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

endmodule

// File: tb/test_cls_action_resolver.sv
module test_cls_action_resolver;

    localparam int NP = 6;
    localparam int PW = 3;
    localparam int TW = 4;
    localparam int VW = 12;
    localparam int MW = 3;
    localparam int FW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          in_valid, rule_hit, remark_pcp_en, remark_dscp_en, remark_cls_en;
    logic          flow_id_en, fwd_ok;
    logic [2:0]    fwd_mode, snoop_mode;
    logic [1:0]    learn_mode, tc_mode, meter_mode, vlan_mode;
    logic [1:0]    xstate_mode, xvlan_mode, crit_mode, irq_mode, tstamp_mode;
    logic [NP-1:0] alt_port_map, dflt_port_map;
    logic [TW-1:0] alt_tc, dflt_tc;
    logic [VW-1:0] alt_vid, dflt_vid;
    logic [MW-1:0] meter_base;
    logic [FW-1:0] flow_id;
    logic [PW-1:0] cpu_port;

    logic          out_valid, out_mc_router, out_mc_learn, out_learn;
    logic [NP-1:0] out_port_map;
    logic [2:0]    out_snoop_type;
    logic [TW-1:0] out_tc;
    logic          out_meter0_en, out_meter1_en;
    logic [MW-1:0] out_meter0_id, out_meter1_id;
    logic [VW-1:0] out_vid;
    logic          out_bypass_state, out_bypass_vlan, out_critical, out_irq, out_tstamp;
    logic          out_remark_pcp, out_remark_dscp, out_remark_cls, out_flow_en, out_conflict;
    logic [FW-1:0] out_flow_id;

    cls_action_resolver #(
        .NUM_PORTS(NP), .PORT_IDX_W(PW), .TC_W(TW), .VID_W(VW), .METER_W(MW), .FLOW_W(FW)
    ) i_cls_action_resolver (.*);

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic rnd_inputs();
        in_valid       = 1'($urandom);
        rule_hit       = ($urandom % 4) != 0;
        fwd_mode       = 3'($urandom);
        snoop_mode     = ($urandom % 3 == 0) ? 3'($urandom) : 3'd0;
        learn_mode     = 2'($urandom);
        tc_mode        = 2'($urandom);
        meter_mode     = 2'($urandom);
        vlan_mode      = 2'($urandom);
        xstate_mode    = 2'($urandom);
        xvlan_mode     = 2'($urandom);
        crit_mode      = 2'($urandom);
        irq_mode       = 2'($urandom);
        tstamp_mode    = 2'($urandom);
        alt_port_map   = NP'($urandom);
        dflt_port_map  = NP'($urandom);
        alt_tc         = TW'($urandom);
        dflt_tc        = TW'($urandom);
        alt_vid        = VW'($urandom);
        dflt_vid       = VW'($urandom);
        meter_base     = MW'($urandom);
        flow_id        = FW'($urandom);
        cpu_port       = PW'($urandom);
        remark_pcp_en  = 1'($urandom);
        remark_dscp_en = 1'($urandom);
        remark_cls_en  = 1'($urandom);
        flow_id_en     = 1'($urandom);
        fwd_ok         = 1'($urandom);
    endtask

    function automatic logic [NP-1:0] exp_map();
        if (!rule_hit || snoop_mode != 3'd0) return dflt_port_map;
        case (fwd_mode)
            3'd2:    return '0;
            3'd3:    return (int'(cpu_port) < NP) ? NP'(1) << cpu_port : '0;
            3'd4:    return alt_port_map;
            default: return dflt_port_map;
        endcase
    endfunction

    function automatic logic exp_learn();
        if (!rule_hit) return fwd_ok;
        if (learn_mode == 2'd2) return 1'b0;
        if (learn_mode == 2'd3) return 1'b1;
        return fwd_ok;
    endfunction

    function automatic logic flag_of(logic [1:0] m);
        return rule_hit && (m == 2'd2);
    endfunction

    // called after the clock edge that captured the current inputs
    task automatic check_all();
        string t;
        logic  clash, fl_en, m0, m1;
        logic [MW-1:0] id0, id1;
        t     = rule_hit ? "R3" : "R2";
        clash = rule_hit && flow_id_en && fwd_mode == 3'd4;
        fl_en = rule_hit && flow_id_en && !clash;
        m0    = rule_hit && (meter_mode == 2'd1 || meter_mode == 2'd3);
        m1    = rule_hit && (meter_mode == 2'd2 || meter_mode == 2'd3);
        id0   = m0 ? meter_base : '0;
        id1   = !m1 ? '0 : (meter_mode == 2'd3) ? MW'(meter_base + 1) : meter_base;

        chk("R12", "valid", 32'(out_valid), 32'(in_valid));
        if (rule_hit && snoop_mode != 3'd0) t = "R4";
        chk(t, "port map", 32'(out_port_map), 32'(exp_map()));
        chk(t, "mc router", 32'(out_mc_router),
            32'(rule_hit && snoop_mode == 3'd0 && fwd_mode == 3'd5));
        chk(t, "mc learn", 32'(out_mc_learn),
            32'(rule_hit && snoop_mode == 3'd0 && fwd_mode == 3'd6));
        chk("R4", "snoop type", 32'(out_snoop_type), rule_hit ? 32'(snoop_mode) : 32'd0);
        chk("R5", "learn", 32'(out_learn), 32'(exp_learn()));
        chk("R6", "class", 32'(out_tc),
            (rule_hit && tc_mode == 2'd2) ? 32'(alt_tc) : 32'(dflt_tc));
        chk("R7", "meter slot0", {out_meter0_en, 31'(out_meter0_id)}, {m0, 31'(id0)});
        chk("R7", "meter slot1", {out_meter1_en, 31'(out_meter1_id)}, {m1, 31'(id1)});
        chk("R8", "vlan", 32'(out_vid),
            (rule_hit && vlan_mode == 2'd2) ? 32'(alt_vid) : 32'(dflt_vid));
        chk("R9", "flags",
            32'({out_bypass_state, out_bypass_vlan, out_critical, out_irq, out_tstamp}),
            32'({flag_of(xstate_mode), flag_of(xvlan_mode), flag_of(crit_mode),
                 flag_of(irq_mode), flag_of(tstamp_mode)}));
        chk("R10", "remark", 32'({out_remark_pcp, out_remark_dscp, out_remark_cls}),
            rule_hit ? 32'({remark_pcp_en, remark_dscp_en, remark_cls_en}) : 32'd7);
        chk("R11", "conflict", 32'(out_conflict), 32'(clash));
        chk("R11", "flow", {out_flow_en, 31'(out_flow_id)},
            {fl_en, 31'(fl_en ? flow_id : '0)});
    endtask

    task automatic step_check();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        void'($urandom(32'd4242));
        rnd_inputs();
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset
        chk("R1", "valid in reset", 32'(out_valid), 32'd0);
        chk("R1", "map in reset", 32'(out_port_map), 32'd0);
        chk("R1", "remark in reset", 32'({out_remark_pcp, out_remark_dscp, out_remark_cls}), 32'd0);
        rst_n = 1'b1;

        // R2: miss uses defaults
        rnd_inputs(); rule_hit = 1'b0; in_valid = 1'b1;
        irq_mode = 2'd2; meter_mode = 2'd3; flow_id_en = 1'b1;
        step_check();

        // R3: CPU port out of range gives empty map
        rnd_inputs(); rule_hit = 1'b1; snoop_mode = 3'd0; fwd_mode = 3'd3; cpu_port = 3'd7;
        step_check();
        cpu_port = 3'd5;
        step_check();
        fwd_mode = 3'd7;
        step_check();

        // R4: snooping overrides the alternative map
        rnd_inputs(); rule_hit = 1'b1; fwd_mode = 3'd4; snoop_mode = 3'd2;
        alt_port_map = 6'h2A; dflt_port_map = 6'h15;
        step_check();

        // R5: forced learning against both forwarding results
        rnd_inputs(); rule_hit = 1'b1; learn_mode = 2'd3; fwd_ok = 1'b0;
        step_check();
        learn_mode = 2'd2; fwd_ok = 1'b1;
        step_check();

        // R7: meter pair wraps at the top of the range
        rnd_inputs(); rule_hit = 1'b1; meter_mode = 2'd3; meter_base = 3'd7;
        step_check();

        // R11: flow tag together with the alternative map
        rnd_inputs(); rule_hit = 1'b1; snoop_mode = 3'd0; fwd_mode = 3'd4; flow_id_en = 1'b1;
        step_check();

        for (int i = 0; i < 3000; i++) begin
            rnd_inputs();
            step_check();
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule